// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block produces the word address for a four-beat burst into a synchronous memory. A burst starts when either of two address strobes is high at a rising clock edge. On that edge the block captures the full start address and the ordering mode. After that, each clock edge with the advance input high moves the burst one beat forward. Only the two low address bits change during a burst. The upper bits stay at the captured value.

Two orderings are supported. In linear ordering the low bits count up from the start value and wrap within the four-word group. In interleaved ordering the low bits are the start value XOR the beat number. The memory array, the data path and the write control are outside this block.

The outputs come directly from registers and combinational logic. A strobe or an advance seen at one edge is therefore visible at the ports one cycle later.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is active, and after it is released with no strobe yet, `addr_out` is all zeros and `beat_idx` is 0.
- R2: When `host_strobe` or `ctrl_strobe` (both active high) is 1 at a rising edge, `addr_out` equals the `addr_in` sampled on that edge and `beat_idx` is 0 from the next cycle.
- R3: When `advance` is 1 at an edge with no strobe, `beat_idx` rises by one, modulo 4.
- R4: With linear ordering (`order_sel` = 0 at the capturing edge), `addr_out[1:0]` = (start low bits + `beat_idx`) mod 4.
- R5: With interleaved ordering (`order_sel` = 1 at the capturing edge), `addr_out[1:0]` = start low bits XOR `beat_idx`.
- R6: Without a strobe, `addr_out` bits above bit 1 never change.
- R7: An advance taken at beat 3 returns `beat_idx` to 0 and the low bits to their start value. The burst never moves into the next four-word group.
- R8: A strobe in the middle of a burst reloads the address and clears the beat count. A strobe has priority over an advance at the same edge.
- R9: `order_sel` is sampled only at an edge that has a strobe. A change of `order_sel` at any other time does not alter the sequence produced.
- R10: At an edge with neither a strobe nor an advance, `addr_out` and `beat_idx` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_strobe | input | 1 | First address strobe, active high |
| ctrl_strobe | input | 1 | Second address strobe, active high |
| advance | input | 1 | Step the burst by one beat |
| order_sel | input | 1 | 0 = linear ordering, 1 = interleaved ordering; captured with a strobe |
| addr_in | input | ADDR_W | Start address |
| addr_out | output | ADDR_W | Current burst address |
| beat_idx | output | 2 | Beat index within the burst |

## Verification
A wrong beat count, a wrong base or a wrong captured mode shows up at `addr_out` or `beat_idx` in the cycle after the edge that caused it. Every state element feeds the ports directly, with no buffering in between. For this reason the bench compares both outputs with a behavioural model on every clock.

Directed bursts cover:
- both orderings from every start offset,
- the wrap past beat 3,
- reloads in the middle of a burst,
- a strobe and an advance at the same edge,
- changes of `order_sel` while no strobe is present.

A long random run follows the directed bursts, so that a wrong state cannot go unobserved for more than one cycle.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
    typedef enum logic {
        ORD_LINEAR = 1'b0,
        ORD_XOR    = 1'b1
    } order_e;
endpackage

// File: rtl/bseq_load_reg.sv
module bseq_load_reg
    import bseq_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr_in,
    input  order_e            order_in,
    output logic [ADDR_W-1:0] base_addr,
    output order_e            order_out
);
    typedef struct packed {
        logic [ADDR_W-1:0] base;
        order_e            order;
    } load_st_t;

    load_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.base  = addr_in;
            st_d.order = order_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{base: '0, order: ORD_LINEAR};
        end else begin
            st_q <= st_d;
        end
    end

    assign base_addr = st_q.base;
    assign order_out = st_q.order;

    // R9: the captured mode changes only on a load edge
    p_order_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(order_out));
endmodule

// File: rtl/bseq_beat_ctr.sv
module bseq_beat_ctr #(
    parameter int LOW_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    output logic [LOW_W-1:0] beat
);
    localparam logic [LOW_W-1:0] LAST_BEAT = '1;

    typedef struct packed {
        logic [LOW_W-1:0] cnt;
    } ctr_st_t;

    ctr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d.cnt = '0;
        end else if (step) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign beat = st_q.cnt;

    p_clear_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (beat == '0));
    p_step_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clear && beat != LAST_BEAT) |=> (beat == $past(beat) + 1'b1));
    p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clear && beat == LAST_BEAT) |=> (beat == '0));
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !clear) |=> $stable(beat));
endmodule

// File: rtl/bseq_low_map.sv
module bseq_low_map
    import bseq_pkg::*;
#(
    parameter int LOW_W = 2
) (
    input  logic [LOW_W-1:0] start_low,
    input  logic [LOW_W-1:0] beat,
    input  order_e           order,
    output logic [LOW_W-1:0] low_out
);
    logic [LOW_W-1:0] lin_low;
    logic [LOW_W-1:0] xor_low;

    // linear: add with carry dropped at LOW_W bits, so the group wraps
    assign lin_low = start_low + beat;

    for (genvar i = 0; i < LOW_W; i++) begin : g_xor_bit
        assign xor_low[i] = start_low[i] ^ beat[i];
    end

    always_comb begin
        unique case (order)
            ORD_XOR:    low_out = xor_low;
            default:    low_out = lin_low;
        endcase
    end

    // R4/R5: beat zero always returns the start offset in both orderings
    always_comb begin
        if (beat == '0) begin
            a_beat0_start_r4: assert (low_out == start_low);
        end
    end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import bseq_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int LOW_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_strobe,
    input  logic              ctrl_strobe,
    input  logic              advance,
    input  logic              order_sel,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out,
    output logic [LOW_W-1:0]  beat_idx
);
    localparam int HI_W = ADDR_W - LOW_W;

    logic              load;
    logic              step;
    logic [ADDR_W-1:0] base_addr;
    order_e            order_q;
    logic [LOW_W-1:0]  low_bits;

    // either strobe starts a burst and wins over advance
    assign load = host_strobe | ctrl_strobe;
    assign step = advance & ~load;

    bseq_load_reg #(.ADDR_W(ADDR_W)) u_load (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .addr_in  (addr_in),
        .order_in (order_e'(order_sel)),
        .base_addr(base_addr),
        .order_out(order_q)
    );

    bseq_beat_ctr #(.LOW_W(LOW_W)) u_ctr (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(load),
        .step (step),
        .beat (beat_idx)
    );

    bseq_low_map #(.LOW_W(LOW_W)) u_map (
        .start_low(base_addr[LOW_W-1:0]),
        .beat     (beat_idx),
        .order    (order_q),
        .low_out  (low_bits)
    );

    assign addr_out = {base_addr[ADDR_W-1:LOW_W], low_bits};

    p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (addr_out == $past(addr_in) && beat_idx == '0));
    p_upper_fixed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(addr_out[ADDR_W-1:LOW_W]));
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !advance) |=> ($stable(addr_out) && $stable(beat_idx)));
    p_strobe_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (load && advance) |=> (beat_idx == '0));

    initial begin
        a_width_ok: assert (HI_W > 0);
    end
endmodule

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb;
    localparam int  AW     = 20;
    localparam time PERIOD = 10ns;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_strobe = 1'b0;
    logic          ctrl_strobe = 1'b0;
    logic          advance = 1'b0;
    logic          order_sel = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic [AW-1:0] addr_out;
    logic [1:0]    beat_idx;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // behavioural model state
    logic [AW-1:0] m_base = '0;
    logic [1:0]    m_beat = 2'd0;
    bit            m_xor  = 0;

    always #(PERIOD/2) clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW), .LOW_W(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .host_strobe(host_strobe), .ctrl_strobe(ctrl_strobe),
        .advance(advance), .order_sel(order_sel), .addr_in(addr_in),
        .addr_out(addr_out), .beat_idx(beat_idx)
    );

    function automatic logic [AW-1:0] exp_addr();
        logic [1:0] lo;
        if (m_xor) lo = m_base[1:0] ^ m_beat;
        else       lo = m_base[1:0] + m_beat;
        return {m_base[AW-1:2], lo};
    endfunction

    task automatic check(string tag);
        total++;
        if (addr_out !== exp_addr() || beat_idx !== m_beat) begin
            bad++;
            $display("FAIL %s: addr=%h beat=%0d expected addr=%h beat=%0d",
                     tag, addr_out, beat_idx, exp_addr(), m_beat);
        end
    endtask

    // called at a falling edge: drive, take the rising edge, compare at next fall
    task automatic cyc(bit h, bit c, bit a, bit m, logic [AW-1:0] ad, string tag);
        host_strobe = h; ctrl_strobe = c; advance = a; order_sel = m; addr_in = ad;
        @(posedge clk);
        if (h || c) begin
            m_base = ad; m_beat = 2'd0; m_xor = m;
        end else if (a) begin
            m_beat = m_beat + 2'd1;
        end
        @(negedge clk);
        check(tag);
    endtask

    initial begin
        #(PERIOD * 100000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: run hung, actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        check("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release");

        // linear burst from every start offset, via both strobes
        for (int s = 0; s < 4; s++) begin
            cyc(s[0], ~s[0], 0, 0, 20'hA5A50 | AW'(s), "R2 capture linear");
            for (int k = 0; k < 4; k++) cyc(0, 0, 1, 0, '0, "R4 linear beat");
        end
        // interleaved burst from every start offset
        for (int s = 0; s < 4; s++) begin
            cyc(~s[0], s[0], 0, 1, 20'h3C3C0 | AW'(s), "R2 capture interleaved");
            for (int k = 0; k < 3; k++) cyc(0, 0, 1, 1, '0, "R5 interleaved beat");
            cyc(0, 0, 1, 1, '0, "R7 wrap to start");
            cyc(0, 0, 1, 1, '0, "R6 upper fixed after wrap");
        end
        // hold with no advance
        cyc(1, 0, 0, 0, 20'hFFFFE, "R2 capture");
        cyc(0, 0, 1, 0, '0, "R3 step");
        cyc(0, 0, 0, 0, '0, "R10 hold");
        cyc(0, 0, 0, 1, '0, "R10 hold");
        // mid-burst reload and strobe priority
        cyc(0, 0, 1, 0, '0, "R3 step");
        cyc(0, 1, 0, 1, 20'h12347, "R8 reload mid burst");
        cyc(0, 0, 1, 1, '0, "R5 after reload");
        cyc(1, 0, 1, 1, 20'h00009, "R8 strobe beats advance");
        // mode change without strobe ignored
        cyc(0, 0, 1, 0, '0, "R9 mode ignored");
        cyc(0, 0, 1, 0, '0, "R9 mode ignored");
        cyc(0, 0, 1, 1, '0, "R9 mode ignored");

        // random mix
        for (int i = 0; i < 400; i++) begin
            int r;
            r = $urandom_range(0, 9);
            cyc(r == 0, r == 1, $urandom_range(0, 3) != 0, 1'($urandom_range(0, 1)),
                AW'($urandom), "random R8 R9 R10");
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule